// File: doc/BRIEF.md
# Eight-Level-Cell Single-Cell ECC Codec

This block protects 64-bit data held in memory whose cells store three bits each. The encoder appends 8 check bits to the data and leaves the data field as it is. The decoder reads back a 72-bit word and works out an 8-bit syndrome. Any error pattern that stays inside one 3-bit cell is corrected: one, two or all three bits of that cell may be flipped. The decoder reports whether it made a correction, or whether the syndrome points to damage it cannot repair.

The word has 24 cells, each made of three adjacent bit positions (3k, 3k+1 and 3k+2). A cell can be hit by 7 nonzero patterns, so 168 distinct syndromes have to be recognised. The parity-check matrix is built when the design elaborates. The check positions carry unit columns, and the data cells carry columns from a GF(32) multiplier lift, which makes the 168 syndromes distinct by construction. Each output bit compares the syndrome against the four syndromes that include that bit inside its own cell. A parameter adds an optional register stage on the decoder outputs.

Top module: `selcc_codec`

## Requirements
- R1: `enc_check_o[i]` is the XOR of the data bits whose matrix column has bit (7-i) set. The stored codeword is `{enc_check_o, enc_data_i}`, and the column of codeword position 64+i is the unit vector with bit (7-i) set.
- R2: The data-cell columns are built as follows:
  - The multiplier values a_k are taken as the nonzero values a (1 to 31), in ascending order, for which the low 3 bits of a·5 are not 3'b011. Products are in GF(32) with polynomial x^5+x^2+1.
  - For k<21, the column of position 3k+j is `{a_k·2^j (5 bits), 3'b1<<j}`.
  - The column of position 63 is 8'h1D.
- R3: A word whose syndrome is zero produces `dec_data_o` equal to the received data bits, with both flags low.
- R4: Any nonzero error pattern confined to one cell that covers at least one data bit is removed completely: `dec_data_o` equals the original data, `dec_corr_o`=1 and `dec_uncorr_o`=0.
- R5: Any nonzero error pattern that touches only check positions (cells 22 and 23, or bits 64 and 65 of cell 21) leaves `dec_data_o` equal to the original data, with `dec_corr_o`=1 and `dec_uncorr_o`=0.
- R6: A nonzero syndrome that matches none of the 168 cell syndromes sets `dec_uncorr_o`=1 and `dec_corr_o`=0, and passes the received data bits through unchanged.
- R7: The two flags are never high together, and the corrected data never differs from the received data in more than 3 bits.
- R8: With `OUT_REG`=0 the decoder is combinational. With `OUT_REG`=1 its outputs appear one clock later, and they are zero while `rst_ni` is low.
- R9: The encoder is combinational for either value of `OUT_REG`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional decoder output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enc_data_i | input | 64 | Data to encode |
| enc_check_o | output | 8 | Check bits for `enc_data_i` |
| dec_word_i | input | 72 | Received word: check bits in [71:64], data bits in [63:0] |
| dec_data_o | output | 64 | Corrected data |
| dec_corr_o | output | 1 | Syndrome matched a single-cell pattern |
| dec_uncorr_o | output | 1 | Nonzero syndrome with no match |

## Verification
Every one of the 7 patterns is injected into every one of the 24 cells, on several data words (all zeros, all ones, alternating bits and random values). This separates a wrong flip selection inside a cell from a wrong column, and it shows that a data bit is repaired in every cell position. Patterns that fall only on check bits show whether the data path stays untouched while the flag still rises. Cross-cell double errors, picked so that their syndromes alias no correctable pattern, separate a correct uncorrectable report from a silent miscorrection. Encoder outputs for unit-vector data expose each matrix column one at a time.

// File: rtl/selcc_pkg.sv
package selcc_pkg;
  parameter int unsigned DATA_W = 64;
  parameter int unsigned CHK_W  = 8;
  parameter int unsigned CELL_W = 3;

  localparam int unsigned CW_W    = DATA_W + CHK_W;
  localparam int unsigned N_CELL  = CW_W / CELL_W;
  localparam int unsigned N_PAT   = (1 << CELL_W) - 1;
  localparam int unsigned N_DCELL = (DATA_W - 1) / CELL_W;
  localparam int unsigned LIFT_W  = CHK_W - CELL_W;
  localparam logic [LIFT_W-1:0] LIFT_RED  = 5'h05;  // x^5 + x^2 + 1, top bit implicit
  localparam logic [CHK_W-1:0]  SPLIT_COL = 8'h1D;  // column of the data bit sharing a cell with check bits

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [CHK_W-1:0]  syn_t;
  typedef logic [CW_W-1:0]   word_t;
  typedef logic [CW_W-1:0][CHK_W-1:0] hmat_t;

  function automatic logic [LIFT_W-1:0] lift_mul(input logic [LIFT_W-1:0] a,
                                                 input logic [LIFT_W-1:0] b);
    logic [LIFT_W-1:0] acc;
    logic [LIFT_W-1:0] t;
    acc = '0;
    t   = a;
    for (int i = 0; i < int'(LIFT_W); i++) begin
      if (b[i]) acc = acc ^ t;
      t = t[LIFT_W-1] ? ((t << 1) ^ LIFT_RED) : (t << 1);
    end
    return acc;
  endfunction

  // A multiplier is usable when its cell shares no nonzero vector with the split cell.
  function automatic logic lift_ok(input logic [LIFT_W-1:0] a);
    logic [LIFT_W-1:0] p;
    p = lift_mul(a, LIFT_W'(SPLIT_COL[CELL_W-1:0]));
    return p[CELL_W-1:0] != SPLIT_COL[2*CELL_W-1:CELL_W];
  endfunction

  function automatic hmat_t build_h();
    hmat_t h;
    int unsigned k;
    logic [LIFT_W-1:0] a;
    h = '0;
    k = 0;
    for (int c = 1; c < (1 << LIFT_W); c++) begin
      a = LIFT_W'(c);
      if (k < N_DCELL && lift_ok(a)) begin
        for (int j = 0; j < int'(CELL_W); j++)
          h[CELL_W*k + j] = {lift_mul(a, LIFT_W'(1 << j)), CELL_W'(1 << j)};
        k++;
      end
    end
    h[DATA_W-1] = SPLIT_COL;
    for (int b = 0; b < int'(CHK_W); b++)
      h[CW_W-1-b] = CHK_W'(1) << b;
    return h;
  endfunction

  localparam hmat_t H = build_h();

  function automatic word_t row_mask(input int b);
    word_t m;
    for (int p = 0; p < int'(CW_W); p++) m[p] = H[p][b];
    return m;
  endfunction

  // syndrome of error pattern m (bit j flips position CELL_W*c+j)
  function automatic syn_t cell_pat(input int c, input int m);
    syn_t s;
    s = '0;
    for (int j = 0; j < int'(CELL_W); j++)
      if (m[j]) s = s ^ H[CELL_W*c + j];
    return s;
  endfunction

  // patterns (index m-1) that include bit j of the cell
  function automatic logic [N_PAT-1:0] flip_sel(input int j);
    logic [N_PAT-1:0] v;
    for (int m = 1; m <= int'(N_PAT); m++) v[m-1] = m[j];
    return v;
  endfunction
endpackage

// File: rtl/selcc_enc.sv
module selcc_enc
  import selcc_pkg::*;
(
  input  data_t data_i,
  output syn_t  check_o
);
  for (genvar i = 0; i < CHK_W; i++) begin : g_chk
    localparam word_t ROW = row_mask(CHK_W - 1 - i);
    localparam data_t DROW = ROW[DATA_W-1:0];
    assign check_o[i] = ^(data_i & DROW);
  end
endmodule

// File: rtl/selcc_syn.sv
module selcc_syn
  import selcc_pkg::*;
(
  input  word_t word_i,
  output syn_t  syn_o
);
  for (genvar b = 0; b < CHK_W; b++) begin : g_syn
    localparam word_t ROW = row_mask(b);
    assign syn_o[b] = ^(word_i & ROW);
  end
endmodule

// File: rtl/selcc_fix.sv
module selcc_fix
  import selcc_pkg::*;
(
  input  syn_t  syn_i,
  input  data_t data_i,
  output data_t data_o,
  output logic  corr_o,
  output logic  uncorr_o
);
  logic [N_CELL-1:0][N_PAT-1:0] hit;
  logic [N_CELL-1:0]            cell_hit;
  data_t                        flip;

  for (genvar c = 0; c < N_CELL; c++) begin : g_cell
    for (genvar m = 1; m <= N_PAT; m++) begin : g_pat
      localparam syn_t PAT = cell_pat(c, m);
      assign hit[c][m-1] = (syn_i == PAT);
    end
    assign cell_hit[c] = |hit[c];
    for (genvar j = 0; j < CELL_W; j++) begin : g_bit
      if (CELL_W*c + j < DATA_W) begin : g_data
        localparam logic [N_PAT-1:0] SEL = flip_sel(j);
        assign flip[CELL_W*c + j] = |(hit[c] & SEL);
      end
    end
  end

  assign data_o   = data_i ^ flip;
  assign corr_o   = |cell_hit;
  assign uncorr_o = (|syn_i) & ~corr_o;
endmodule

// File: rtl/selcc_codec.sv
module selcc_codec
  import selcc_pkg::*;
#(
  parameter bit OUT_REG = 1'b0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [DATA_W-1:0]    enc_data_i,
  output logic [CHK_W-1:0]     enc_check_o,
  input  logic [CW_W-1:0]      dec_word_i,
  output logic [DATA_W-1:0]    dec_data_o,
  output logic                 dec_corr_o,
  output logic                 dec_uncorr_o
);
  syn_t  syn;
  data_t fix_data;
  logic  fix_corr;
  logic  fix_uncorr;

  selcc_enc u_enc (
    .data_i  (enc_data_i),
    .check_o (enc_check_o)
  );

  selcc_syn u_syn (
    .word_i (dec_word_i),
    .syn_o  (syn)
  );

  selcc_fix u_fix (
    .syn_i    (syn),
    .data_i   (dec_word_i[DATA_W-1:0]),
    .data_o   (fix_data),
    .corr_o   (fix_corr),
    .uncorr_o (fix_uncorr)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dec_data_o   <= '0;
        dec_corr_o   <= 1'b0;
        dec_uncorr_o <= 1'b0;
      end else begin
        dec_data_o   <= fix_data;
        dec_corr_o   <= fix_corr;
        dec_uncorr_o <= fix_uncorr;
      end
    end
  end else begin : g_comb
    logic unused_clk_rst;
    assign unused_clk_rst = clk_i ^ rst_ni;
    assign dec_data_o   = fix_data;
    assign dec_corr_o   = fix_corr;
    assign dec_uncorr_o = fix_uncorr;
  end
endmodule

// File: rtl/selcc_codec_chk.sv
module selcc_codec_chk
  import selcc_pkg::*;
#(
  parameter bit OUT_REG = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] enc_data_i,
  input logic [CHK_W-1:0]  enc_check_o,
  input logic [CW_W-1:0]   dec_word_i,
  input logic [DATA_W-1:0] dec_data_o,
  input logic              dec_corr_o,
  input logic              dec_uncorr_o
);
  word_t ref_word;
  logic  ref_clean;

  if (OUT_REG) begin : g_lat
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ref_word  <= '0;
        ref_clean <= 1'b0;
      end else begin
        ref_word  <= dec_word_i;
        ref_clean <= (dec_word_i == {enc_check_o, enc_data_i});
      end
    end
  end else begin : g_now
    assign ref_word  = dec_word_i;
    assign ref_clean = (dec_word_i == {enc_check_o, enc_data_i});
  end

  // R7
  flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dec_corr_o && dec_uncorr_o));

  // R7
  flip_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(dec_data_o ^ ref_word[DATA_W-1:0]) <= CELL_W);

  // R6
  uncorr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_uncorr_o |-> dec_data_o == ref_word[DATA_W-1:0]);

  // R3 R1
  clean_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_clean |-> (!dec_corr_o && !dec_uncorr_o && dec_data_o == ref_word[DATA_W-1:0]));

  // R3
  quiet_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dec_corr_o && !dec_uncorr_o) |-> dec_data_o == ref_word[DATA_W-1:0]);
endmodule

bind selcc_codec selcc_codec_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .enc_data_i   (enc_data_i),
  .enc_check_o  (enc_check_o),
  .dec_word_i   (dec_word_i),
  .dec_data_o   (dec_data_o),
  .dec_corr_o   (dec_corr_o),
  .dec_uncorr_o (dec_uncorr_o)
);

// File: tb/selcc_codec_tb_top.sv
module selcc_codec_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] enc_data_i = '0;
  logic [7:0]  enc_check_o;
  logic [71:0] dec_word_i = '1;
  logic [63:0] dec_data_o;
  logic        dec_corr_o;
  logic        dec_uncorr_o;

  always #2 clk = ~clk;  // 250 MHz

  selcc_codec #(.OUT_REG(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .enc_data_i(enc_data_i), .enc_check_o(enc_check_o),
    .dec_word_i(dec_word_i), .dec_data_o(dec_data_o),
    .dec_corr_o(dec_corr_o), .dec_uncorr_o(dec_uncorr_o)
  );

  typedef struct {
    logic [63:0] data;
    logic        corr;
    logic        uncorr;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t mon_e;
  int checks = 0;
  int errors = 0;
  logic [7:0] hb [72];
  bit good [256];

  // GF(32), x^5+x^2+1 (R2)
  function automatic logic [4:0] gmul(input logic [4:0] x, input logic [4:0] y);
    logic [4:0] r = '0;
    logic [4:0] s = x;
    for (int i = 0; i < 5; i++) begin
      if (y[i]) r ^= s;
      s = s[4] ? ({s[3:0], 1'b0} ^ 5'b00101) : {s[3:0], 1'b0};
    end
    return r;
  endfunction

  task automatic build_ref();
    int k = 0;
    logic [4:0] pr;
    for (int a = 1; a < 32; a++) begin
      pr = gmul(5'(a), 5'd5);
      if (pr[2:0] != 3'b011 && k < 21) begin
        for (int j = 0; j < 3; j++) hb[3*k+j] = {gmul(5'(a), 5'(1 << j)), 3'(1 << j)};
        k++;
      end
    end
    hb[63] = 8'h1D;
    for (int i = 0; i < 8; i++) hb[64+i] = 8'h80 >> i;
    for (int s = 0; s < 256; s++) good[s] = 1'b0;
    for (int c = 0; c < 24; c++)
      for (int m = 1; m < 8; m++) begin
        logic [7:0] sy = '0;
        for (int j = 0; j < 3; j++) if (m[j]) sy ^= hb[3*c+j];
        good[sy] = 1'b1;
      end
  endtask

  function automatic logic [7:0] enc_ref(input logic [63:0] d);
    logic [7:0] c = '0;
    for (int i = 0; i < 8; i++)
      for (int p = 0; p < 64; p++) c[i] ^= d[p] & hb[p][7-i];
    return c;
  endfunction

  task automatic drive(input logic [71:0] w, input logic [63:0] d,
                       input logic co, input logic un, input string tag);
    exp_t e;
    @(negedge clk);
    dec_word_i = w;
    e.data = d; e.corr = co; e.uncorr = un; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic check_enc(input logic [63:0] d, input string tag);
    @(negedge clk);
    enc_data_i = d;
    #1;
    checks++;
    if (enc_check_o !== enc_ref(d)) begin
      errors++;
      $display("FAIL %s enc data=%h check=%h exp=%h", tag, d, enc_check_o, enc_ref(d));
    end
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    if (rst_ni && q.size() > 0) begin
      #1;
      mon_e = q.pop_front();
      checks++;
      if (dec_data_o !== mon_e.data || dec_corr_o !== mon_e.corr || dec_uncorr_o !== mon_e.uncorr) begin
        errors++;
        $display("FAIL %s data=%h exp=%h corr=%b exp=%b uncorr=%b exp=%b", mon_e.tag,
                 dec_data_o, mon_e.data, dec_corr_o, mon_e.corr, dec_uncorr_o, mon_e.uncorr);
      end
      checks++;
      if (dec_corr_o === 1'b1 && dec_uncorr_o === 1'b1) begin
        errors++;
        $display("FAIL R7 both flags high corr=%b uncorr=%b exp=not both", dec_corr_o, dec_uncorr_o);
      end
    end
  end

  initial begin : watchdog
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [63:0] pats [4];
    logic [71:0] cw;
    logic [71:0] err;
    int found;
    build_ref();
    pats[0] = '0;
    pats[1] = '1;
    pats[2] = 64'hAAAA_5555_AAAA_5555;
    pats[3] = {$urandom, $urandom};

    // R8 reset state
    repeat (3) @(negedge clk);
    checks++;
    if (dec_data_o !== '0 || dec_corr_o !== 1'b0 || dec_uncorr_o !== 1'b0) begin
      errors++;
      $display("FAIL R8 reset data=%h corr=%b uncorr=%b exp=0/0/0", dec_data_o, dec_corr_o, dec_uncorr_o);
    end
    rst_ni = 1'b1;

    // R1 R9 encoder, R2 columns via unit vectors
    for (int i = 0; i < 4; i++) check_enc(pats[i], "R1 R9");
    for (int p = 0; p < 64; p += 7) check_enc(64'(1) << p, "R2");
    check_enc(64'(1) << 63, "R2");

    // R3 clean words, R8 latency
    drive({enc_ref(pats[1]), pats[1]}, pats[1], 1'b0, 1'b0, "R3");
    drive({enc_ref(pats[2]), pats[2]}, pats[2], 1'b0, 1'b0, "R3");
    #1;
    checks++;
    if (dec_data_o !== pats[1]) begin
      errors++;
      $display("FAIL R8 latency data=%h exp=%h", dec_data_o, pats[1]);
    end
    for (int i = 0; i < 4; i++) drive({enc_ref(pats[i]), pats[i]}, pats[i], 1'b0, 1'b0, "R3");

    // R4 R5 every pattern in every cell
    for (int i = 0; i < 4; i++) begin
      cw = {enc_ref(pats[i]), pats[i]};
      for (int c = 0; c < 24; c++)
        for (int m = 1; m < 8; m++) begin
          err = 72'(m) << (3 * c);
          drive(cw ^ err, pats[i], 1'b1, 1'b0, (|err[63:0]) ? "R4" : "R5");
        end
    end

    // R6 cross-cell doubles with unused syndromes
    found = 0;
    for (int i = 0; i < 4; i++) begin
      cw = {enc_ref(pats[i]), pats[i]};
      for (int p = 0; p < 60; p++)
        if (!good[hb[p] ^ hb[p+4]] && found < 24) begin
          err = (72'(1) << p) | (72'(1) << (p + 4));
          drive(cw ^ err, pats[i] ^ err[63:0], 1'b0, 1'b1, "R6");
          found++;
        end
    end
    checks++;
    if (found == 0) begin
      errors++;
      $display("FAIL R6 no uncorrectable pattern found=%0d exp>0", found);
    end

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule